// File: doc/BRIEF.md
# SPI Register Read Transactor

This block is an SPI master that performs one register read as a single framed transaction. A one-cycle start request carries a 7-bit register address. The engine drops the active-low chip select and waits a programmable setup time. It then clocks out a command byte: the address with its top bit forced to one to mark a read. Next it clocks out a zero filler byte and captures the byte the peripheral returns on the serial input. After a programmable hold time it releases chip select. The captured byte is presented together with a one-cycle completion strobe.

The serial clock comes from the system clock. Its half period is a programmable number of system cycles. Clock polarity and phase are selectable, so all four common SPI modes are covered. Timing and mode inputs are latched when a request is accepted. They may change freely while a read is in flight.

Top module: `spi_reg_reader`

## Requirements
- R1: While reset is asserted, chip select is high and busy, done, SCLK, MOSI and read data are all zero.
- R2: A start pulse seen while idle is accepted at that clock edge. From the next cycle busy is high and chip select is low. Start pulses while busy have no effect on the frame in flight or on its result.
- R3: The first SCLK edge occurs S system cycles after chip select falls. S is the setup input, and 0 counts as 1.
- R4: Successive SCLK edges are H system cycles apart. H is the half-period input, and 0 counts as 1. A frame has exactly 32 edges, which is 16 SCLK periods.
- R5: Chip select rises T system cycles after the last SCLK edge. T is the hold input, and 0 counts as 1. Busy falls in that same cycle.
- R6: SCLK idles at the polarity input. With phase 0, data is sampled on odd-numbered edges (1, 3, …) and MOSI advances on even edges. With phase 1, data is sampled on even edges and MOSI advances on odd edges after the first.
- R7: MOSI carries {1, addr[6:0]} and then 8'h00, most significant bit first. The first bit is on MOSI from the cycle chip select falls.
- R8: The read data is the last eight MISO samples of the frame, first sample in bit 7. The eight samples taken during the command byte are discarded.
- R9: Done is high for exactly one cycle, in the cycle chip select rises. Read data changes only in that cycle and otherwise holds its value.
- R10: While idle, MOSI is low and SCLK follows the polarity input with one cycle of delay.
- R11: Address, mode, half period and hold are taken at acceptance. Changing them mid-frame does not alter the frame.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | System clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| start_i | input | 1 | Request a read (single-cycle pulse) |
| addr_i | input | 7 | Register address |
| cpol_i | input | 1 | SCLK idle level |
| cpha_i | input | 1 | Sampling phase: 0 leading edge, 1 trailing edge |
| half_div_i | input | 8 | SCLK half period in system cycles |
| setup_i | input | 8 | Chip-select-to-first-edge delay in system cycles |
| hold_i | input | 8 | Last-edge-to-chip-select-release delay in system cycles |
| miso_i | input | 1 | Serial data from peripheral |
| sclk_o | output | 1 | Serial clock |
| mosi_o | output | 1 | Serial data to peripheral |
| cs_no | output | 1 | Chip select, active low |
| busy_o | output | 1 | Transaction in progress |
| done_o | output | 1 | One-cycle completion strobe |
| rdata_o | output | 8 | Captured register value |

## Verification
Each timing result falls at a fixed offset from the accepting edge, taking S, H and T after clamping:
- Busy and chip select change one cycle after acceptance.
- SCLK edge n appears S+(n-1)·H cycles after acceptance.
- Chip select release, done and the new read data all appear at S+31·H+T.

The bench model counts cycles from the accepting edge and derives every expected output from that count. It drives MISO from its own sample count. All outputs are compared at the falling clock edge of every cycle. A one-cycle slip in any counter therefore shows as a mismatch.

// File: rtl/spi_rr_pkg.sv
package spi_rr_pkg;
  typedef enum logic [1:0] {
    ST_IDLE,
    ST_SETUP,
    ST_SHIFT,
    ST_HOLD
  } rr_state_e;

  typedef struct packed {
    logic cpol;
    logic cpha;
  } rr_mode_t;
endpackage

// File: rtl/spi_rr_ctrl.sv
module spi_rr_ctrl
  import spi_rr_pkg::*;
#(
  parameter int unsigned DATA_W = 8,
  parameter int unsigned DIV_W  = 8,
  parameter int unsigned GAP_W  = 8,
  localparam int unsigned EDGES  = 4 * DATA_W,
  localparam int unsigned EDGE_W = $clog2(EDGES + 1),
  localparam int unsigned CNT_W  = (DIV_W > GAP_W) ? DIV_W : GAP_W
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              start_i,
  input  rr_mode_t          mode_i,
  input  logic [DIV_W-1:0]  half_i,
  input  logic [GAP_W-1:0]  setup_i,
  input  logic [GAP_W-1:0]  hold_i,
  output logic              accept_o,
  output logic              fire_o,
  output logic [EDGE_W-1:0] edge_num_o,
  output logic              finish_o,
  output logic              idle_o,
  output logic              busy_o,
  output logic              cs_no,
  output rr_mode_t          mode_o
);
  rr_state_e         state_q;
  logic [CNT_W-1:0]  cnt_q;
  logic [CNT_W-1:0]  half_m1_q;
  logic [CNT_W-1:0]  hold_m1_q;
  logic [EDGE_W-1:0] edges_q;
  logic              cs_n_q;
  rr_mode_t          mode_q;
  logic [CNT_W-1:0]  half_m1, setup_m1, hold_m1;
  logic              cnt_zero;

  // zero-valued intervals are treated as one cycle
  always_comb begin
    half_m1  = (half_i  == '0) ? '0 : CNT_W'(half_i)  - CNT_W'(1);
    setup_m1 = (setup_i == '0) ? '0 : CNT_W'(setup_i) - CNT_W'(1);
    hold_m1  = (hold_i  == '0) ? '0 : CNT_W'(hold_i)  - CNT_W'(1);
  end

  assign cnt_zero   = (cnt_q == '0);
  assign accept_o   = (state_q == ST_IDLE) && start_i;
  assign fire_o     = ((state_q == ST_SETUP) || (state_q == ST_SHIFT)) && cnt_zero;
  assign edge_num_o = edges_q + EDGE_W'(1);
  assign finish_o   = (state_q == ST_HOLD) && cnt_zero;
  assign idle_o     = (state_q == ST_IDLE);
  assign busy_o     = (state_q != ST_IDLE);
  assign cs_no      = cs_n_q;
  assign mode_o     = mode_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      state_q   <= ST_IDLE;
      cnt_q     <= '0;
      half_m1_q <= '0;
      hold_m1_q <= '0;
      edges_q   <= '0;
      cs_n_q    <= 1'b1;
      mode_q    <= '0;
    end else begin
      unique case (state_q)
        ST_IDLE: begin
          if (start_i) begin
            state_q   <= ST_SETUP;
            cnt_q     <= setup_m1;
            half_m1_q <= half_m1;
            hold_m1_q <= hold_m1;
            mode_q    <= mode_i;
            edges_q   <= '0;
            cs_n_q    <= 1'b0;
          end
        end
        ST_SETUP: begin
          if (cnt_zero) begin
            state_q <= ST_SHIFT;
            cnt_q   <= half_m1_q;
            edges_q <= EDGE_W'(1);
          end else begin
            cnt_q <= cnt_q - CNT_W'(1);
          end
        end
        ST_SHIFT: begin
          if (cnt_zero) begin
            edges_q <= edges_q + EDGE_W'(1);
            if (edges_q == EDGE_W'(EDGES - 1)) begin
              state_q <= ST_HOLD;
              cnt_q   <= hold_m1_q;
            end else begin
              cnt_q <= half_m1_q;
            end
          end else begin
            cnt_q <= cnt_q - CNT_W'(1);
          end
        end
        ST_HOLD: begin
          if (cnt_zero) begin
            state_q <= ST_IDLE;
            cs_n_q  <= 1'b1;
          end else begin
            cnt_q <= cnt_q - CNT_W'(1);
          end
        end
        default: state_q <= ST_IDLE;
      endcase
    end
  end

  AST_EDGE_BOUND: assert property (@(posedge clk_i) disable iff (!rst_ni)
    edges_q <= EDGE_W'(EDGES)); // R4
  AST_HOLD_AFTER_ALL_EDGES: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (state_q == ST_HOLD) |-> (edges_q == EDGE_W'(EDGES))); // R5
  AST_CS_TRACKS_BUSY: assert property (@(posedge clk_i) disable iff (!rst_ni)
    cs_n_q == (state_q == ST_IDLE)); // R2
  AST_CFG_FROZEN: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (state_q != ST_IDLE) |=> ($stable(half_m1_q) && $stable(mode_q) && $stable(hold_m1_q))); // R11
endmodule

// File: rtl/spi_rr_sclk.sv
module spi_rr_sclk (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic idle_i,
  input  logic cpol_i,
  input  logic fire_i,
  output logic sclk_o
);
  logic sclk_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)     sclk_q <= 1'b0;
    else if (idle_i) sclk_q <= cpol_i;
    else if (fire_i) sclk_q <= ~sclk_q;
  end

  assign sclk_o = sclk_q;

  AST_SCLK_ONLY_ON_FIRE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!idle_i && !fire_i) |=> $stable(sclk_q)); // R4
endmodule

// File: rtl/spi_rr_shifter.sv
module spi_rr_shifter #(
  parameter int unsigned DATA_W = 8,
  localparam int unsigned ADDR_W  = DATA_W - 1,
  localparam int unsigned FRAME_W = 2 * DATA_W,
  localparam int unsigned EDGES   = 2 * FRAME_W,
  localparam int unsigned EDGE_W  = $clog2(EDGES + 1)
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              load_i,
  input  logic [ADDR_W-1:0] addr_i,
  input  logic              fire_i,
  input  logic [EDGE_W-1:0] edge_num_i,
  input  logic              cpha_i,
  input  logic              active_i,
  input  logic              miso_i,
  output logic              mosi_o,
  output logic [DATA_W-1:0] rx_o
);
  logic [FRAME_W-1:0] tx_q;
  logic [DATA_W-1:0]  rx_q;
  logic               odd_edge, sample, advance;

  assign odd_edge = edge_num_i[0];
  // phase 0 samples odd edges, phase 1 samples even edges
  assign sample   = fire_i && (odd_edge != cpha_i);
  assign advance  = fire_i && (odd_edge == cpha_i)
                    && (edge_num_i != EDGE_W'(1)) && (edge_num_i != EDGE_W'(EDGES));

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      tx_q <= '0;
      rx_q <= '0;
    end else if (load_i) begin
      tx_q <= {1'b1, addr_i, {DATA_W{1'b0}}};
      rx_q <= '0;
    end else begin
      if (advance) tx_q <= {tx_q[FRAME_W-2:0], 1'b0};
      if (sample)  rx_q <= {rx_q[DATA_W-2:0], miso_i};
    end
  end

  assign mosi_o = active_i & tx_q[FRAME_W-1];
  assign rx_o   = rx_q;

  AST_SAMPLE_XOR_ADVANCE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !(sample && advance)); // R6
endmodule

// File: rtl/spi_reg_reader.sv
module spi_reg_reader
  import spi_rr_pkg::*;
#(
  parameter int unsigned DATA_W = 8,
  parameter int unsigned DIV_W  = 8,
  parameter int unsigned GAP_W  = 8,
  localparam int unsigned ADDR_W = DATA_W - 1,
  localparam int unsigned EDGE_W = $clog2(4 * DATA_W + 1)
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              start_i,
  input  logic [ADDR_W-1:0] addr_i,
  input  logic              cpol_i,
  input  logic              cpha_i,
  input  logic [DIV_W-1:0]  half_div_i,
  input  logic [GAP_W-1:0]  setup_i,
  input  logic [GAP_W-1:0]  hold_i,
  input  logic              miso_i,
  output logic              sclk_o,
  output logic              mosi_o,
  output logic              cs_no,
  output logic              busy_o,
  output logic              done_o,
  output logic [DATA_W-1:0] rdata_o
);
  rr_mode_t          mode_in, mode_lat;
  logic              accept, fire, finish, idle, cs_n;
  logic [EDGE_W-1:0] edge_num;
  logic [DATA_W-1:0] rx;
  logic              done_q;
  logic [DATA_W-1:0] rdata_q;

  assign mode_in = '{cpol: cpol_i, cpha: cpha_i};

  spi_rr_ctrl #(.DATA_W(DATA_W), .DIV_W(DIV_W), .GAP_W(GAP_W)) u_ctrl (
    .clk_i, .rst_ni, .start_i,
    .mode_i     (mode_in),
    .half_i     (half_div_i),
    .setup_i,
    .hold_i,
    .accept_o   (accept),
    .fire_o     (fire),
    .edge_num_o (edge_num),
    .finish_o   (finish),
    .idle_o     (idle),
    .busy_o,
    .cs_no      (cs_n),
    .mode_o     (mode_lat)
  );

  spi_rr_sclk u_sclk (
    .clk_i, .rst_ni,
    .idle_i (idle),
    .cpol_i,
    .fire_i (fire),
    .sclk_o
  );

  spi_rr_shifter #(.DATA_W(DATA_W)) u_shift (
    .clk_i, .rst_ni,
    .load_i     (accept),
    .addr_i,
    .fire_i     (fire),
    .edge_num_i (edge_num),
    .cpha_i     (mode_lat.cpha),
    .active_i   (~cs_n),
    .miso_i,
    .mosi_o,
    .rx_o       (rx)
  );

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      done_q  <= 1'b0;
      rdata_q <= '0;
    end else begin
      done_q <= finish;
      if (finish) rdata_q <= rx;
    end
  end

  assign cs_no   = cs_n;
  assign done_o  = done_q;
  assign rdata_o = rdata_q;

  AST_DONE_SINGLE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    done_o |=> !done_o); // R9
  AST_RDATA_STABLE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !done_o |-> $stable(rdata_o)); // R9
  AST_DONE_WITH_RELEASE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    done_o |-> (cs_no && !busy_o)); // R5
endmodule

// File: tb/spi_reg_reader_tb.sv
module spi_reg_reader_tb_top;
  logic       clk = 1'b0;
  logic       rst_n;
  logic       start, cpol, cpha, miso;
  logic [6:0] addr;
  logic [7:0] half, setup, hold;
  logic       sclk, mosi, cs_n, busy, done;
  logic [7:0] rdata;

  int checks = 0;
  int fails  = 0;
  int cyc    = 0;

  always #5 clk = ~clk;

  spi_reg_reader dut_i (
    .clk_i(clk), .rst_ni(rst_n), .start_i(start), .addr_i(addr),
    .cpol_i(cpol), .cpha_i(cpha), .half_div_i(half), .setup_i(setup),
    .hold_i(hold), .miso_i(miso), .sclk_o(sclk), .mosi_o(mosi),
    .cs_no(cs_n), .busy_o(busy), .done_o(done), .rdata_o(rdata)
  );

  // behavioural reference
  logic [15:0] tb_reply;
  logic [15:0] m_tx, m_reply;
  logic        m_busy, m_done, m_pol, m_cpol, m_cpha;
  logic [7:0]  m_rdata;
  int          m_t, m_s, m_h, m_hold, m_len;

  function automatic int clamp1(input int v);
    return (v == 0) ? 1 : v;
  endfunction

  function automatic int m_edges();
    int n;
    if (m_t < m_s) return 0;
    n = (m_t - m_s) / m_h + 1;
    return (n > 32) ? 32 : n;
  endfunction

  always @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      m_busy = 0; m_done = 0; m_pol = 0; m_rdata = 0; m_t = 0;
      m_s = 1; m_h = 1; m_hold = 1; m_len = 0;
      m_tx = 0; m_reply = 0; m_cpol = 0; m_cpha = 0;
    end else if (m_busy) begin
      m_t++;
      m_done = 0;
      if (m_t == m_len) begin
        m_busy = 0; m_done = 1; m_rdata = m_reply[7:0];
      end
    end else begin
      m_done = 0;
      m_pol  = cpol;
      if (start) begin
        m_busy = 1; m_t = 0;
        m_s = clamp1(int'(setup)); m_h = clamp1(int'(half)); m_hold = clamp1(int'(hold));
        m_len = m_s + 31 * m_h + m_hold;
        m_cpol = cpol; m_cpha = cpha;
        m_tx = {1'b1, addr, 8'h00};
        m_reply = tb_reply;
      end
    end
  end

  always @(posedge clk) begin
    cyc++;
    if (cyc == 150000) begin
      fails++;
      $display("FAIL watchdog: actual=running expected=finished");
      $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
      $finish;
    end
  end

  task automatic check(input string what, input string req, input int act, input int exp);
    checks++;
    if (act != exp) begin
      fails++;
      $display("FAIL %s %s at cycle %0d: actual=%0h expected=%0h", req, what, cyc, act, exp);
    end
  endtask

  // one cycle: compare at falling edge, then drive MISO from the model
  task automatic step();
    int n, k, sc;
    @(negedge clk);
    n = m_edges();
    k = m_cpha ? ((n == 0) ? 0 : (n - 1) / 2) : n / 2;
    if (k > 15) k = 15;
    sc = m_cpha ? n / 2 : (n + 1) / 2;
    check("cs_n",  "R3", int'(cs_n), int'(!m_busy));      // also R2 R5
    check("busy",  "R2", int'(busy), int'(m_busy));       // also R5
    check("done",  "R9", int'(done), int'(m_done));
    check("rdata", "R8", int'(rdata), int'(m_rdata));     // also R9
    if (m_busy) begin
      check("sclk", "R6", int'(sclk), int'(m_cpol ^ n[0])); // also R4 R11
      check("mosi", "R7", int'(mosi), int'(m_tx[15-k]));
    end else begin
      check("sclk idle", "R10", int'(sclk), int'(m_pol));
      check("mosi idle", "R10", int'(mosi), 0);
    end
    miso = (m_busy && sc < 16) ? m_reply[15-sc] : 1'b0;
  endtask

  task automatic launch(input logic [6:0] a, input logic pol, input logic pha,
                        input int h, input int s, input int t, input logic [15:0] rep);
    addr = a; cpol = pol; cpha = pha; half = 8'(h); setup = 8'(s); hold = 8'(t);
    tb_reply = rep; start = 1'b1;
    step();
    start = 1'b0;
  endtask

  task automatic wait_idle();
    while (m_busy) step();
    repeat (3) step();
  endtask

  initial begin
    rst_n = 1'b0; start = 0; addr = 0; cpol = 0; cpha = 0;
    half = 1; setup = 1; hold = 1; miso = 0; tb_reply = 0;
    repeat (3) @(negedge clk);
    // R1 reset values
    check("cs_n rst",  "R1", int'(cs_n), 1);
    check("busy rst",  "R1", int'(busy), 0);
    check("done rst",  "R1", int'(done), 0);
    check("sclk rst",  "R1", int'(sclk), 0);
    check("mosi rst",  "R1", int'(mosi), 0);
    check("rdata rst", "R1", int'(rdata), 0);
    rst_n = 1'b1;
    repeat (3) step();

    // mode 0
    launch(7'h32, 0, 0, 2, 2, 2, 16'hC35A);
    wait_idle();
    check("rdata mode0", "R8", int'(rdata), 8'h5A);

    // mode 1, minimum timing
    launch(7'h7F, 0, 1, 1, 1, 1, 16'h0FA3);
    wait_idle();
    check("rdata mode1", "R8", int'(rdata), 8'hA3);

    // idle polarity follows input, R10
    cpol = 1; repeat (3) step();

    // mode 2, zero setup clamps; ignored start and config change mid-frame (R2, R11)
    launch(7'h00, 1, 0, 3, 0, 4, 16'h5501);
    repeat (7) step();
    addr = 7'h11; cpol = 0; cpha = 1; half = 1; hold = 9; tb_reply = 16'hFFFF; start = 1;
    step();
    start = 0;
    wait_idle();
    check("rdata ignored start", "R2", int'(rdata), 8'h01);

    // mode 3, zero half and hold clamp; start held across done (back-to-back)
    cpol = 1; repeat (2) step();
    launch(7'h15, 1, 1, 0, 5, 0, 16'h96E7);
    start = 1'b1;
    while (!m_done) step();
    tb_reply = 16'h3C80;
    step();
    start = 1'b0;
    wait_idle();
    check("rdata back-to-back", "R9", int'(rdata), 8'h80);

    // long spacing, mode 0
    cpol = 0; repeat (2) step();
    launch(7'h2A, 0, 0, 5, 3, 6, 16'hAAFE);
    wait_idle();
    check("rdata slow", "R4", int'(rdata), 8'hFE);

    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end
endmodule